// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation entries from memory. The top 10 bits of the address pick an entry in a directory. The directory's physical location is taken from a base register. The next 10 bits pick an entry in the table that the directory entry points to. The low 12 bits pass through as the offset inside a 4 KiB page. Each entry is one 32-bit word, so its byte address is the table's frame address plus four times the index.

A client offers one address at a time together with a control word and the directory base. When bit 31 of the control word is clear, paging is off and the block returns the address unchanged without touching memory. When it is set, the block makes one or two memory reads through a request/response port. It then returns either the translated address or a fault whose code names the point where the walk stopped. Only one translation is in flight at a time.

Top module: `xlate_walker`

## Requirements
- R1: Right after reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: If bit 31 of `req_ctrl` is 0 when a request is accepted, `rsp_valid` rises on the next cycle with `rsp_paddr` equal to the request address and `rsp_fault` = 0. No memory read is issued.
- R3: With paging on, the first read is at {`req_base`[31:12], va[31:22], 2'b00}. Bits [11:0] of `req_base` have no effect.
- R4: The second read is at {dir_entry[31:12], va[21:12], 2'b00}.
- R5: A successful walk responds with `rsp_paddr` = {table_entry[31:12], va[11:0]}, `rsp_fault` = 0 and `rsp_code` = 0.
- R6: A directory entry with bit 0 (present) clear ends the walk after one read, with `rsp_fault` = 1 and `rsp_code` = 1.
- R7: A table entry equal to zero (not mapped) gives `rsp_fault` = 1 and `rsp_code` = 2.
- R8: A nonzero table entry with bit 0 clear (not present) gives `rsp_fault` = 1 and `rsp_code` = 3.
- R9: `req_ready` stays 0 from acceptance up to and including the response cycle. Requests offered in that time are ignored and produce no response.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` holds its value.
- R11: The address, control word and base are captured at acceptance. Later changes to `req_ctrl` or `req_base` do not alter the walk in progress.
- R12: `rsp_valid` is a single-cycle pulse per accepted request. `rsp_code` is nonzero exactly when `rsp_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_vaddr | input | 32 | Linear address to translate |
| req_ctrl | input | 32 | Control word; bit 31 enables paging |
| req_base | input | 32 | Physical address of the directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Walk stopped with a fault |
| rsp_code | output | 2 | 0 none, 1 directory absent, 2 table unmapped, 3 table absent |

## Verification
On every cycle the assertions enforce the single-pulse response and the agreement of code and fault flag. They also check that a stalled memory request holds steady, that an idle block issues nothing, that the bypass result arrives one cycle after acceptance, and that the first read lands at the address formed from the captured base and directory index. Only the bench scenarios can show that entry contents steer the walk correctly. That covers the frame taken from each level, the fault code for each kind of bad entry, the skipped second read after a directory fault, and the results under memory backpressure and variable latency. The bench also shows that inputs changed mid-walk, and requests offered while busy, leave the result untouched.

// File: rtl/xw_pkg.sv
package xw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_DIR = 3'd1,
      ST_RD_PTE = 3'd2,
      ST_DONE   = 3'd3,
      ST_FAULT  = 3'd4
   } xw_state_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_DIR    = 2'd1,
      FLT_EMPTY  = 2'd2,
      FLT_ABSENT = 2'd3
   } xw_fault_e;

endpackage

// File: rtl/xw_index_split.sv
module xw_index_split #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int OFF_W  = 12,
   parameter int LEVELS = 2
) (
   input  logic [ADDR_W-1:0]             vaddr,
   output logic [LEVELS-1:0][IDX_W-1:0]  idx,
   output logic [OFF_W-1:0]              off
);

   // level 0 is the directory and takes the uppermost index field
   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      localparam int TOP = ADDR_W - 1 - lv * IDX_W;
      assign idx[lv] = vaddr[TOP -: IDX_W];
   end

   assign off = vaddr[OFF_W-1:0];

endmodule

// File: rtl/xw_entry_decode.sv
module xw_entry_decode #(
   parameter int ENT_W       = 32,
   parameter int OFF_W       = 12,
   parameter int PRESENT_BIT = 0
) (
   input  logic [ENT_W-1:0]        entry,
   output logic [ENT_W-OFF_W-1:0]  frame,
   output logic                    present,
   output logic                    empty
);

   assign frame   = entry[ENT_W-1:OFF_W];
   assign present = entry[PRESENT_BIT];
   assign empty   = (entry == '0);

endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
   import xw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 10,
   parameter int OFF_W     = 12,
   parameter int ENT_SH    = 2,
   parameter int PG_BIT    = 31,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ADDR_W-1:0]         req_vaddr,
   input  logic [31:0]               req_ctrl,
   input  logic [ADDR_W-1:0]         req_base,
   output logic                      mem_req_valid,
   input  logic                      mem_req_ready,
   output logic [ADDR_W-1:0]         mem_req_addr,
   input  logic                      mem_rsp_valid,
   input  logic                      ent_present,
   input  logic                      ent_empty,
   input  logic [ADDR_W-OFF_W-1:0]   ent_frame,
   input  logic [IDX_W-1:0]          idx_dir,
   input  logic [IDX_W-1:0]          idx_tbl,
   input  logic [OFF_W-1:0]          pg_off,
   output logic [ADDR_W-1:0]         va_q,
   output logic                      rsp_valid,
   output logic [ADDR_W-1:0]         rsp_paddr,
   output logic                      rsp_fault,
   output logic [1:0]                rsp_code
);

   localparam int FRM_W = ADDR_W - OFF_W;

   xw_state_e            state_q;
   logic                 issued_q;
   logic [FRM_W-1:0]     base_frm_q;
   logic [FRM_W-1:0]     pde_frm_q;
   logic [ADDR_W-1:0]    paddr_q;
   xw_fault_e            code_q;
   logic                 walk_now;
   logic                 accept;
   logic                 rsp_in;
   logic                 unused_inputs;

   assign unused_inputs = ^{req_ctrl, req_base[OFF_W-1:0]};

   // paging-enable bypass present or stripped out at elaboration
   if (BYPASS_EN) begin : g_bypass
      assign walk_now = req_ctrl[PG_BIT];
   end else begin : g_always_walk
      assign walk_now = 1'b1;
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign mem_req_valid = ((state_q == ST_RD_DIR) || (state_q == ST_RD_PTE)) && !issued_q;
   assign rsp_in        = issued_q && mem_rsp_valid;

   always_comb begin
      if (state_q == ST_RD_PTE) begin
         mem_req_addr = {pde_frm_q, idx_tbl, {ENT_SH{1'b0}}};
      end else begin
         mem_req_addr = {base_frm_q, idx_dir, {ENT_SH{1'b0}}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         issued_q   <= 1'b0;
         va_q       <= '0;
         base_frm_q <= '0;
         pde_frm_q  <= '0;
         paddr_q    <= '0;
         code_q     <= FLT_NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               issued_q <= 1'b0;
               if (accept) begin
                  va_q       <= req_vaddr;
                  base_frm_q <= req_base[ADDR_W-1:OFF_W];
                  code_q     <= FLT_NONE;
                  if (walk_now) begin
                     state_q <= ST_RD_DIR;
                  end else begin
                     paddr_q <= req_vaddr;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_RD_DIR: begin
               if (mem_req_valid && mem_req_ready) begin
                  issued_q <= 1'b1;
               end
               if (rsp_in) begin
                  issued_q <= 1'b0;
                  if (!ent_present) begin
                     code_q  <= FLT_DIR;
                     state_q <= ST_FAULT;
                  end else begin
                     pde_frm_q <= ent_frame;
                     state_q   <= ST_RD_PTE;
                  end
               end
            end
            ST_RD_PTE: begin
               if (mem_req_valid && mem_req_ready) begin
                  issued_q <= 1'b1;
               end
               if (rsp_in) begin
                  issued_q <= 1'b0;
                  if (ent_empty) begin
                     code_q  <= FLT_EMPTY;
                     state_q <= ST_FAULT;
                  end else if (!ent_present) begin
                     code_q  <= FLT_ABSENT;
                     state_q <= ST_FAULT;
                  end else begin
                     paddr_q <= {ent_frame, pg_off};
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DONE, ST_FAULT: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
   assign rsp_fault = (state_q == ST_FAULT);
   assign rsp_paddr = paddr_q;
   assign rsp_code  = code_q;

   // R10: a stalled read keeps its address
   p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R12: response lasts one cycle
   p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R12: code agrees with fault flag
   p_code_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_code != 2'd0)));

   // R9: an idle block issues nothing and reports nothing
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !rsp_valid));

   // R2: bypass result one cycle after acceptance
   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS_EN && req_valid && req_ready && !req_ctrl[PG_BIT]) |=>
         (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

   // R3: first read formed from captured base and directory index
   p_dir_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (!BYPASS_EN || req_ctrl[PG_BIT])) |=>
         (mem_req_valid && mem_req_addr ==
            {$past(req_base[ADDR_W-1:OFF_W]), $past(req_vaddr[ADDR_W-1 -: IDX_W]),
             {ENT_SH{1'b0}}}));

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENT_BYTES   = 4,
   parameter int PRESENT_BIT = 0,
   parameter int PG_BIT      = 31,
   parameter bit BYPASS_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_vaddr,
   input  logic [31:0]        req_ctrl,
   input  logic [ADDR_W-1:0]  req_base,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ADDR_W-1:0]  mem_rsp_data,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_paddr,
   output logic               rsp_fault,
   output logic [1:0]         rsp_code
);

   localparam int LEVELS = 2;
   localparam int ENT_SH = $clog2(ENT_BYTES);
   localparam int FRM_W  = ADDR_W - OFF_W;

   if (ADDR_W != LEVELS * IDX_W + OFF_W) begin : g_bad_split
      $error("address width must equal two indices plus the offset");
   end
   if (OFF_W != IDX_W + ENT_SH) begin : g_bad_table
      $error("one table of entries must fill exactly one page");
   end
   if ((1 << ENT_SH) != ENT_BYTES) begin : g_bad_entry
      $error("entry size must be a power of two");
   end
   if (PRESENT_BIT >= OFF_W || PG_BIT > 31) begin : g_bad_bits
      $error("flag bit positions out of range");
   end

   logic [ADDR_W-1:0]            va_q;
   logic [LEVELS-1:0][IDX_W-1:0] idx;
   logic [OFF_W-1:0]             pg_off;
   logic [FRM_W-1:0]             ent_frame;
   logic                         ent_present;
   logic                         ent_empty;

   xw_index_split #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .OFF_W  (OFF_W),
      .LEVELS (LEVELS)
   ) u_split (
      .vaddr (va_q),
      .idx   (idx),
      .off   (pg_off)
   );

   xw_entry_decode #(
      .ENT_W       (ADDR_W),
      .OFF_W       (OFF_W),
      .PRESENT_BIT (PRESENT_BIT)
   ) u_decode (
      .entry   (mem_rsp_data),
      .frame   (ent_frame),
      .present (ent_present),
      .empty   (ent_empty)
   );

   xw_walk_ctrl #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .OFF_W     (OFF_W),
      .ENT_SH    (ENT_SH),
      .PG_BIT    (PG_BIT),
      .BYPASS_EN (BYPASS_EN)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_ctrl      (req_ctrl),
      .req_base      (req_base),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .ent_present   (ent_present),
      .ent_empty     (ent_empty),
      .ent_frame     (ent_frame),
      .idx_dir       (idx[0]),
      .idx_tbl       (idx[1]),
      .pg_off        (pg_off),
      .va_q          (va_q),
      .rsp_valid     (rsp_valid),
      .rsp_paddr     (rsp_paddr),
      .rsp_fault     (rsp_fault),
      .rsp_code      (rsp_code)
   );

endmodule

// File: tb/xlate_walker_tb.sv
module xlate_walker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] req_ctrl = '0;
   logic [31:0] req_base = '0;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic [1:0]  rsp_code;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   xlate_walker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_ctrl(req_ctrl), .req_base(req_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_code(rsp_code)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem [int unsigned];
   int          lat = 1;
   bit          stall = 1'b0;
   int          cyc = 0;
   int          wait_n = 0;
   logic [31:0] pend_addr = '0;
   int          n_acc = 0;
   logic [31:0] acc_addr [4];
   logic        rsp_v_q = 1'b0;
   logic [31:0] rsp_d_q = '0;

   assign mem_req_ready = !stall || (cyc % 3 == 2);
   assign mem_rsp_valid = rsp_v_q;
   assign mem_rsp_data  = rsp_d_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      rsp_v_q <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         pend_addr <= mem_req_addr;
         wait_n <= lat;
         if (n_acc < 4) acc_addr[n_acc] <= mem_req_addr;
         n_acc <= n_acc + 1;
      end else if (wait_n != 0) begin
         wait_n <= wait_n - 1;
         if (wait_n == 1) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired: actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_ea(input logic [31:0] base, input logic [31:0] va);
      return {base[31:12], va[31:22], 2'b00};
   endfunction
   function automatic logic [31:0] tbl_ea(input logic [31:0] pde, input logic [31:0] va);
      return {pde[31:12], va[21:12], 2'b00};
   endfunction

   // result of the last translation
   logic [31:0] r_paddr;
   logic        r_fault;
   logic [1:0]  r_code;
   int          r_cycles;
   int          r_rsp_cnt;

   // offer one request; optionally keep offering another while busy or alter inputs
   task automatic run(input logic [31:0] va, input logic [31:0] ctrl,
                      input logic [31:0] base, input bit meddle);
      bit busy_ok;
      @(negedge clk);
      n_acc = 0;
      req_valid = 1'b1; req_vaddr = va; req_ctrl = ctrl; req_base = base;
      @(negedge clk);
      if (meddle) begin
         req_vaddr = ~va; req_ctrl = ~ctrl; req_base = base ^ 32'h0F0F_F000;
      end else begin
         req_valid = 1'b0;
      end
      r_cycles = 1;
      busy_ok = 1'b1;
      while (!rsp_valid && r_cycles < 200) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         r_cycles++;
      end
      r_paddr = rsp_paddr; r_fault = rsp_fault; r_code = rsp_code;
      if (meddle) begin
         chk(busy_ok && !req_ready, "R9 ready low while busy", {31'd0, req_ready}, 32'd0);
      end
      req_valid = 1'b0;
      r_rsp_cnt = 0;
      repeat (6) begin
         @(negedge clk);
         if (rsp_valid) r_rsp_cnt++;
      end
      chk(r_rsp_cnt == 0, "R12 single response pulse", r_rsp_cnt, 0);
   endtask

   // ---------------- scenarios ----------------
   localparam logic [31:0] PG   = 32'h8000_0000;
   localparam logic [31:0] BASE = 32'h0001_0000;

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 1);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 0);
   endtask

   task automatic t_bypass();
      run(32'hDEAD_BEEF, 32'h7FFF_FFFF, BASE, 1'b0);
      chk(r_cycles == 1, "R2 bypass latency", r_cycles, 1);
      chk(r_paddr == 32'hDEAD_BEEF, "R2 bypass paddr", r_paddr, 32'hDEAD_BEEF);
      chk(!r_fault, "R2 bypass no fault", {31'd0, r_fault}, 0);
      chk(n_acc == 0, "R2 bypass no memory read", n_acc, 0);
   endtask

   task automatic t_walk_ok(input logic [31:0] va, input logic [31:0] base,
                            input logic [31:0] pde, input logic [31:0] pte);
      logic [31:0] exp_pa;
      mem[dir_ea(base, va)] = pde;
      mem[tbl_ea(pde, va)]  = pte;
      exp_pa = {pte[31:12], va[11:0]};
      run(va, PG, base, 1'b0);
      chk(n_acc == 2, "R5 two reads", n_acc, 2);
      chk(acc_addr[0] == dir_ea(base, va), "R3 directory read address", acc_addr[0], dir_ea(base, va));
      chk(acc_addr[1] == tbl_ea(pde, va), "R4 table read address", acc_addr[1], tbl_ea(pde, va));
      chk(!r_fault && r_code == 2'd0, "R5 no fault code", {30'd0, r_code}, 0);
      chk(r_paddr == exp_pa, "R5 translated paddr", r_paddr, exp_pa);
   endtask

   task automatic t_dir_absent();
      logic [31:0] va = 32'h4000_1234;
      mem[dir_ea(BASE, va)] = 32'h0003_0FFE;
      run(va, PG, BASE, 1'b0);
      chk(r_fault && r_code == 2'd1, "R6 directory absent code", {30'd0, r_code}, 1);
      chk(n_acc == 1, "R6 single read only", n_acc, 1);
   endtask

   task automatic t_tbl_empty();
      logic [31:0] va = 32'h0080_2000;
      mem[dir_ea(BASE, va)] = 32'h0004_0001;
      mem[tbl_ea(32'h0004_0001, va)] = 32'h0;
      run(va, PG, BASE, 1'b0);
      chk(r_fault && r_code == 2'd2, "R7 table unmapped code", {30'd0, r_code}, 2);
   endtask

   task automatic t_tbl_absent();
      logic [31:0] va = 32'h0080_3000;
      mem[dir_ea(BASE, va)] = 32'h0004_0001;
      mem[tbl_ea(32'h0004_0001, va)] = 32'h5555_5000;
      run(va, PG, BASE, 1'b0);
      chk(r_fault && r_code == 2'd3, "R8 table not present code", {30'd0, r_code}, 3);
      chk(n_acc == 2, "R8 both reads made", n_acc, 2);
   endtask

   task automatic t_busy_and_meddle();
      logic [31:0] va = 32'h1234_5678;
      mem[dir_ea(BASE, va)] = 32'h0002_0003;
      mem[tbl_ea(32'h0002_0003, va)] = 32'hABCD_E007;
      lat = 3;
      run(va, PG, BASE, 1'b1);
      chk(r_paddr == 32'hABCD_E678, "R11 walk unaffected by changed inputs", r_paddr, 32'hABCD_E678);
      chk(acc_addr[0] == dir_ea(BASE, va), "R11 base captured", acc_addr[0], dir_ea(BASE, va));
      chk(n_acc == 2, "R9 second request ignored", n_acc, 2);
      lat = 1;
   endtask

   task automatic t_stall();
      logic [31:0] va = 32'hFFFF_FFFF;
      mem[dir_ea(BASE, va)] = 32'h0007_7001;
      mem[tbl_ea(32'h0007_7001, va)] = 32'h0123_4001;
      stall = 1'b1; lat = 2;
      run(va, PG, BASE, 1'b0);
      chk(r_paddr == 32'h0123_4FFF, "R10 result under backpressure", r_paddr, 32'h0123_4FFF);
      chk(acc_addr[1] == tbl_ea(32'h0007_7001, va), "R10 held table address", acc_addr[1],
          tbl_ea(32'h0007_7001, va));
      stall = 1'b0; lat = 1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_walk_ok(32'h1234_5678, BASE, 32'h0002_0003, 32'hABCD_E007);
      // R3: low base bits ignored
      t_walk_ok(32'h0000_0000, 32'h0005_0ABC, 32'h0006_0001, 32'h0000_1001);
      t_dir_absent();
      t_tbl_empty();
      t_tbl_absent();
      t_busy_and_meddle();
      t_stall();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule